// File: doc/BRIEF.md
# Serial Line Break and Idle Detector

This block watches an asynchronous serial line next to the character receiver and reports two line conditions that the receiver cannot see on its own. A break is a low stretch that lasts at least one full character frame. An idle period is a high stretch of one full frame time. The frame time is derived at run time from the configured frame format and the clocks-per-bit setting. The line may be electrically inverted, and a single control bit restores its logical sense.

When a low stretch ends, the block compares the number of low samples against the frame length. If the stretch was long enough, it emits a one-cycle break pulse together with the measured low length. In the same cycle it tells the character receiver to drop back to waiting for a start bit. While the line stays high, the block emits one idle pulse for every elapsed frame time.

When the receiver finishes a character, it can report how many clocks have passed since that character's start edge. The first idle period is then timed from the end of that character's nominal frame, not from the moment of the report.

Top module: `lbi_line_watch`

## Requirements
- R1: The frame length F in clocks is ceil(H × clks_per_bit / 2), where H counts half-bit periods: H = 2 + 2×data_bits + 2×parity_en + stop_sel. The stop_sel codes mean 0 → no stop bit, 1 → half a bit, 2 → one bit, 3 → one and a half bits. A low run of exactly F samples counts as a break.
- R2: Counting starts at the first low sample after a high sample, and every further low sample adds one to the low run. On the first high sample after a run of at least F low samples, brk_pulse is high for one cycle, starting on the clock edge that follows that sample. In that same cycle, brk_len holds the run length.
- R3: A low run shorter than F samples produces no break pulse.
- R4: The low-run count saturates at 2^CNT_W − 1 and does not wrap. A longer run still breaks and reports that ceiling.
- R5: rcv_abort is high in exactly the cycles in which brk_pulse is high.
- R6: While the line stays high, idle_pulse is high for one cycle after every F counted high samples, and the count restarts after each pulse.
- R7: Any low sample clears the idle count, so the next idle pulse needs F further high samples.
- R8: A rcv_done pulse with rcv_age = A, sampled while the line is high, clears the idle count. The next W high samples are then not counted, where W = F − A if A < F and W = 0 otherwise. The next idle pulse follows the (W+F)-th high sample after the done sample.
- R9: With invert = 1, the line is treated as its complement in every rule above.
- R10: While rst_n is low, brk_pulse, idle_pulse and rcv_abort are 0. The line is taken to be high at reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Serial line, already synchronized to clk |
| invert | input | 1 | 1 = the line is inverted |
| data_bits | input | 4 | Data bits per character (5 to 9) |
| parity_en | input | 1 | 1 = the frame carries a parity bit |
| stop_sel | input | 2 | Stop length code in half bits (0, 0.5, 1, 1.5) |
| clks_per_bit | input | CPB_W | Clock cycles per bit period (at least 1) |
| rcv_done | input | 1 | Receiver finished a character |
| rcv_age | input | CNT_W | Clocks since that character's start edge |
| brk_pulse | output | 1 | One-cycle break report |
| brk_len | output | CNT_W | Low-run length, valid with brk_pulse |
| idle_pulse | output | 1 | One-cycle idle-frame report |
| rcv_abort | output | 1 | Forces the receiver back to waiting for a start bit |

## Verification
A wrong low-run count shows up in the cycle after the rising edge that ends the run. Either a break that should be there is missing, or a spurious one appears, or brk_len differs from the number of low samples that were driven. A wrong idle count or hold-off value moves the idle pulse away from its arithmetic position within one frame time, and every later pulse shifts with it. The bench sweeps every data width, every parity and stop setting, and three bit rates, in both line polarities. Each cycle is compared with counts derived from the requirements.

// File: rtl/lbi_pkg.sv
package lbi_pkg;

    // Width of the half-bit frame count (max 2 + 30 + 2 + 3 = 37).
    localparam int HB_W = 6;

    typedef enum logic [1:0] {
        STOP_NONE     = 2'd0,
        STOP_HALF     = 2'd1,
        STOP_ONE      = 2'd2,
        STOP_ONE_HALF = 2'd3
    } stop_len_e;

endpackage

// File: rtl/lbi_frame_len.sv
module lbi_frame_len #(
    parameter int CPB_W = 12,
    parameter int CNT_W = 20
) (
    input  logic [3:0]       data_bits,
    input  logic             parity_en,
    input  logic [1:0]       stop_sel,
    input  logic [CPB_W-1:0] clks_per_bit,
    output logic [CNT_W-1:0] frame_clks
);
    import lbi_pkg::*;

    localparam int PW = HB_W + CPB_W + 1;

    stop_len_e       stop_len;
    logic [HB_W-1:0] halves;
    logic [PW-1:0]   prod;
    logic [PW-1:0]   rounded;

    // R1: count the frame in half bits so that half stop bits stay exact
    always_comb begin
        stop_len = stop_len_e'(stop_sel);
        halves   = HB_W'(2) + HB_W'({data_bits, 1'b0})
                 + HB_W'({parity_en, 1'b0}) + HB_W'(stop_len);
        prod     = PW'(halves) * PW'(clks_per_bit);
        rounded  = (prod + PW'(1)) >> 1;
    end

    generate
        if (PW > CNT_W) begin : g_sat
            localparam logic [PW-1:0] LIM = PW'({CNT_W{1'b1}});
            assign frame_clks = (rounded > LIM) ? {CNT_W{1'b1}} : rounded[CNT_W-1:0];
        end else begin : g_ext
            assign frame_clks = CNT_W'(rounded);
        end
    endgenerate

endmodule

// File: rtl/lbi_break_meter.sv
module lbi_break_meter #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl,
    input  logic [CNT_W-1:0] frame_clks,
    output logic             brk_pulse,
    output logic [CNT_W-1:0] brk_len
);
    typedef struct packed {
        logic             lvl;
        logic [CNT_W-1:0] run;
        logic             pulse;
        logic [CNT_W-1:0] len;
    } meter_t;

    meter_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        st_d.lvl   = lvl;
        if (st_q.lvl && !lvl) begin
            // falling edge: restart the measurement with this low sample
            st_d.run = CNT_W'(1);
        end else if (!st_q.lvl && !lvl) begin
            if (st_q.run != {CNT_W{1'b1}}) begin
                st_d.run = st_q.run + CNT_W'(1);
            end
        end else if (!st_q.lvl && lvl) begin
            if (st_q.run >= frame_clks) begin
                st_d.pulse = 1'b1;
                st_d.len   = st_q.run;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{lvl: 1'b1, run: '0, pulse: 1'b0, len: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign brk_pulse = st_q.pulse;
    assign brk_len   = st_q.len;

    // R4
    low_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.lvl && !lvl) |=> (st_q.run != '0 && st_q.run >= $past(st_q.run)));

    // R2
    brk_len_ge_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |-> (st_q.len >= $past(frame_clks)));

    // R2
    brk_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |=> !st_q.pulse);

endmodule

// File: rtl/lbi_idle_timer.sv
module lbi_idle_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl,
    input  logic [CNT_W-1:0] frame_clks,
    input  logic             rcv_done,
    input  logic [CNT_W-1:0] rcv_age,
    output logic             idle_pulse
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hold;
        logic             pulse;
    } idle_t;

    idle_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (!lvl) begin
            st_d.cnt  = '0;
            st_d.hold = '0;
        end else if (rcv_done) begin
            st_d.cnt  = '0;
            st_d.hold = (rcv_age < frame_clks) ? (frame_clks - rcv_age) : '0;
        end else if (st_q.hold != '0) begin
            st_d.hold = st_q.hold - CNT_W'(1);
        end else if (({1'b0, st_q.cnt} + (CNT_W+1)'(1)) >= {1'b0, frame_clks}) begin
            st_d.pulse = 1'b1;
            st_d.cnt   = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, hold: '0, pulse: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign idle_pulse = st_q.pulse;

    // R7
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl |=> !st_q.pulse);

    // R6
    idle_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pulse && frame_clks > CNT_W'(1)) |=> !st_q.pulse);

endmodule

// File: rtl/lbi_line_watch.sv
module lbi_line_watch #(
    parameter int CPB_W = 12,
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    input  logic             invert,
    input  logic [3:0]       data_bits,
    input  logic             parity_en,
    input  logic [1:0]       stop_sel,
    input  logic [CPB_W-1:0] clks_per_bit,
    input  logic             rcv_done,
    input  logic [CNT_W-1:0] rcv_age,
    output logic             brk_pulse,
    output logic [CNT_W-1:0] brk_len,
    output logic             idle_pulse,
    output logic             rcv_abort
);
    logic             lvl;
    logic [CNT_W-1:0] frame_clks;

    // R9: normalise polarity once for both detectors
    assign lvl = line_in ^ invert;

    lbi_frame_len #(.CPB_W(CPB_W), .CNT_W(CNT_W)) u_len (
        .data_bits    (data_bits),
        .parity_en    (parity_en),
        .stop_sel     (stop_sel),
        .clks_per_bit (clks_per_bit),
        .frame_clks   (frame_clks)
    );

    lbi_break_meter #(.CNT_W(CNT_W)) u_brk (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl        (lvl),
        .frame_clks (frame_clks),
        .brk_pulse  (brk_pulse),
        .brk_len    (brk_len)
    );

    lbi_idle_timer #(.CNT_W(CNT_W)) u_idle (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl        (lvl),
        .frame_clks (frame_clks),
        .rcv_done   (rcv_done),
        .rcv_age    (rcv_age),
        .idle_pulse (idle_pulse)
    );

    // R5
    assign rcv_abort = brk_pulse;

    // R6
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_clks > CNT_W'(1)) |-> !(brk_pulse && idle_pulse));

endmodule

// File: tb/sim_lbi_line_watch.sv
module sim_lbi_line_watch;
    localparam int CPB_W   = 8;
    localparam int CNT_W   = 12;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             line_in = 1'b1;
    logic             invert = 1'b0;
    logic [3:0]       data_bits = 4'd8;
    logic             parity_en = 1'b0;
    logic [1:0]       stop_sel = 2'd2;
    logic [CPB_W-1:0] clks_per_bit = 8'd1;
    logic             rcv_done = 1'b0;
    logic [CNT_W-1:0] rcv_age = '0;
    logic             brk_pulse;
    logic [CNT_W-1:0] brk_len;
    logic             idle_pulse;
    logic             rcv_abort;

    lbi_line_watch #(.CPB_W(CPB_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .invert(invert),
        .data_bits(data_bits), .parity_en(parity_en), .stop_sel(stop_sel),
        .clks_per_bit(clks_per_bit), .rcv_done(rcv_done), .rcv_age(rcv_age),
        .brk_pulse(brk_pulse), .brk_len(brk_len), .idle_pulse(idle_pulse),
        .rcv_abort(rcv_abort)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int F = 6;
    bit m_pl = 1'b1;
    int m_lc = 0, m_hc = 0, m_hold = 0;
    bit cur_v = 1'b1, cur_done = 1'b0;
    int cur_age = 0;
    int brk_seen = 0, idle_seen = 0, last_len = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // observe the result of the previous drive, then drive the next sample
    task automatic run_cycle(input bit v, input bit done, input int age);
        bit s;
        int eb, el, ei;
        @(negedge clk);
        s  = cur_v ^ invert;
        eb = 0; el = 0; ei = 0;
        if (m_pl && !s) m_lc = 1;
        else if (!m_pl && !s) begin
            if (m_lc < CNT_MAX) m_lc++;
        end else if (!m_pl && s && m_lc >= F) begin
            eb = 1; el = m_lc;
        end
        m_pl = s;
        if (!s) begin
            m_hc = 0; m_hold = 0;
        end else if (cur_done) begin
            m_hc = 0; m_hold = (cur_age < F) ? F - cur_age : 0;
        end else if (m_hold > 0) begin
            m_hold--;
        end else begin
            m_hc++;
            if (m_hc >= F) begin ei = 1; m_hc = 0; end
        end
        if (eb == 1)
            check(brk_pulse == 1'b1 && int'(brk_len) == el, "R2 break pulse and length",
                  brk_pulse ? int'(brk_len) : 0, el);
        else
            check(brk_pulse == 1'b0, "R3 no break on short run", int'(brk_pulse), 0);
        check(int'(idle_pulse) == ei, "R6 idle pulse timing", int'(idle_pulse), ei);
        check(rcv_abort == brk_pulse, "R5 abort follows break", int'(rcv_abort), int'(brk_pulse));
        if (brk_pulse) begin brk_seen++; last_len = int'(brk_len); end
        if (idle_pulse) idle_seen++;
        line_in  = v;
        rcv_done = done;
        rcv_age  = CNT_W'(age);
        cur_v    = v;
        cur_done = done;
        cur_age  = age;
    endtask

    task automatic drv(input bit lvl, input int n);
        repeat (n) run_cycle(lvl ^ invert, 1'b0, 0);
    endtask

    task automatic do_reset(input int d, input int p, input int s, input int c, input bit inv);
        int hb;
        rst_n        = 1'b0;
        data_bits    = 4'(d);
        parity_en    = p[0];
        stop_sel     = 2'(s);
        clks_per_bit = CPB_W'(c);
        invert       = inv;
        line_in      = ~inv;
        rcv_done     = 1'b0;
        rcv_age      = '0;
        repeat (2) @(negedge clk);
        check(!brk_pulse && !idle_pulse && !rcv_abort, "R10 outputs quiet in reset",
              int'(brk_pulse) + int'(idle_pulse) + int'(rcv_abort), 0);
        rst_n    = 1'b1;
        cur_v    = ~inv;
        cur_done = 1'b0;
        cur_age  = 0;
        m_pl = 1'b1; m_lc = 0; m_hc = 0; m_hold = 0;
        hb = 2 + 2 * d + 2 * p + s;
        F  = (hb * c + 1) / 2;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R6: run hung, actual 0 expected 1");
        finish_run();
    end

    initial begin
        int idx;
        int n, a, w;
        idx = 0;
        for (int d = 5; d <= 9; d++) begin
            for (int p = 0; p <= 1; p++) begin
                for (int s = 0; s <= 3; s++) begin
                    for (int c = 1; c <= 3; c++) begin
                        idx++;
                        do_reset(d, p, s, c, idx[0]);
                        drv(1'b1, 5);
                        // R3: one sample short of a frame
                        n = brk_seen;
                        drv(1'b0, F - 1);
                        drv(1'b1, 2);
                        check(brk_seen == n, "R3 run of F-1 ignored", brk_seen - n, 0);
                        drv(1'b1, F + 3);
                        // R1 / R9: exactly one frame of low
                        n = brk_seen;
                        drv(1'b0, F);
                        drv(1'b1, 2);
                        check(brk_seen == n + 1,
                              invert ? "R9 inverted line break count" : "R1 break at exactly F",
                              brk_seen - n, 1);
                        check(last_len == F, "R2 measured low length", last_len, F);
                        drv(1'b1, 2 * F);
                        // R7: a single low sample restarts the idle count
                        drv(1'b0, 1);
                        n = idle_seen;
                        drv(1'b1, F);
                        check(idle_seen == n, "R7 idle count cleared by low", idle_seen - n, 0);
                        drv(1'b1, 1);
                        check(idle_seen == n + 1, "R7 idle after F highs", idle_seen - n, 1);
                        // R6: repeated idle reports
                        n = idle_seen;
                        drv(1'b1, 3 * F);
                        check(idle_seen == n + 3, "R6 one idle per frame", idle_seen - n, 3);
                        // R8: receiver-supplied idle reference
                        a = (idx % 3 == 0) ? 0 : ((idx % 3 == 1) ? F / 2 : F + 1);
                        w = (a < F) ? F - a : 0;
                        run_cycle(~invert, 1'b1, a);
                        n = idle_seen;
                        drv(1'b1, w + F);
                        check(idle_seen == n, "R8 idle held off after done", idle_seen - n, 0);
                        drv(1'b1, 1);
                        check(idle_seen == n + 1, "R8 idle after hold-off", idle_seen - n, 1);
                        drv(1'b0, F + 2);
                        drv(1'b1, 3);
                    end
                end
            end
        end
        // R4: run far beyond the counter range
        do_reset(5, 0, 2, 1, 1'b0);
        drv(1'b1, 3);
        n = brk_seen;
        drv(1'b0, 5000);
        drv(1'b1, 2);
        check(brk_seen == n + 1, "R4 saturated run still breaks", brk_seen - n, 1);
        check(last_len == CNT_MAX, "R4 length saturates", last_len, CNT_MAX);
        drv(1'b1, 4);
        finish_run();
    end

endmodule